// File: doc/BRIEF.md
# SPI FIFO Threshold DMA Controller

This block sits between a serial shift engine and the system side of a serial peripheral. It keeps two byte-wide queues, one for transmit and one for receive, each 32 entries deep. It compares their fill levels against thresholds that software programs. From those comparisons it raises DMA requests and sets sticky level interrupt flags, so a DMA engine or an interrupt handler can keep the transmit queue topped up and the receive queue drained.

A small register port has two word addresses. Address 0 is the control word: the two thresholds, the transmit DMA and transmit queue enables, a write-one-only flush of the transmit queue, and the read-only transmit fill count. Address 1 is a write-one-to-clear flag word, which records transmit level, receive level, receive underrun and receive overrun events. The shift engine is modelled by push and pop strobes. A mode input selects master or slave behaviour. In slave mode, a byte that arrives at a full receive queue is dropped and flagged as an overrun. In master mode no overrun is flagged. Instead, a stall output holds the serial clock for as long as the receive queue is full.

The stall output comes from a two-state machine. In state ST_FLOW the clock runs. In state ST_HOLD the clock is held. Transition T_FILL moves ST_FLOW to ST_HOLD when the mode is master and the receive fill count about to be registered equals the depth. Transition T_DRAIN moves ST_HOLD to ST_FLOW when that count drops below the depth or the mode becomes slave. Otherwise the state is kept.

Top module: `spi_fifo_dma_ctl`

## Requirements
- R1: While reset is asserted, the control word reads 0x0000_1000: RX threshold in bits [4:0] is 0, TX threshold in bits [12:8] is 0x10, and the enables in bits 16 and 17 are 0. The flag word reads 0, both DMA requests are low and stall_o is low.
- R2: rx_dma_req_o is high exactly while the RX fill count is greater than the RX threshold (control bits [4:0]). A value n therefore requests at n+1 bytes.
- R3: RX level flag (flag bit 1) is set on the clock edge that ends a cycle in which the RX fill count exceeds the RX threshold. It is therefore visible one cycle after the request.
- R4: tx_dma_req_o is high exactly while the TX DMA enable (control bit 16) is 1 and the TX fill count is below the TX threshold (control bits [12:8]). Writing bit 16 as 0 drops the request from the next cycle. TX level flag (flag bit 0) is set on each edge that ends a cycle in which the fill count is below the threshold, whatever the DMA enable is.
- R5: A TX push is accepted only when the TX queue enable (control bit 17) is 1 and the TX queue is not full; otherwise it is ignored. tx_data_o shows the oldest byte, and a pop on an empty queue is ignored.
- R6: A control write with bit 18 set empties the TX queue and clears flag bit 0 on that edge, and this clear overrides a set of flag bit 0 in the same cycle. A control write with bit 18 clear leaves the queue as it is. Bit 18 always reads 0.
- R7: Control bits [29:24] read the number of bytes in the TX queue, from 0 to 32.
- R8: A pop of the RX queue while it is empty sets the underrun flag (flag bit 2).
- R9: When master_i is 0, a push into a full RX queue drops the byte and sets the overrun flag (flag bit 3). When master_i is 1, that flag is never set.
- R10: stall_o goes high after the edge at which the RX queue becomes full while master_i is 1. It stays high until the edge at which the queue gains room or master_i is 0. It is never high in slave mode.
- R11: Flags are sticky. Writing 1 to a bit of the flag word (address 1) clears it, and writing 0 leaves it unchanged. A set event wins over a clear of the same flag in the same cycle.
- R12: The RX queue returns bytes in arrival order on rx_data_o, and a full queue accepts no further byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Word address: 0 control, 1 flags |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed word |
| master_i | input | 1 | 1 = master mode, 0 = slave mode |
| tx_push_i | input | 1 | Push a byte into the TX queue |
| tx_wdata_i | input | 8 | Byte to push into the TX queue |
| tx_pop_i | input | 1 | Shift engine takes the TX head byte |
| tx_data_o | output | 8 | Oldest byte in the TX queue |
| rx_push_i | input | 1 | Shift engine delivers a received byte |
| rx_wdata_i | input | 8 | Received byte |
| rx_pop_i | input | 1 | Take the RX head byte |
| rx_data_o | output | 8 | Oldest byte in the RX queue |
| tx_dma_req_o | output | 1 | TX DMA request |
| rx_dma_req_o | output | 1 | RX DMA request |
| stall_o | output | 1 | Hold the serial clock (master mode) |

## Verification
A push, pop or register write takes effect on the next rising edge. Just after that edge the fill counts, the head bytes, both DMA requests, stall_o and the control readback show the new state. The flags lag by one more edge, because each flag is set from the counts of the cycle before. The bench drives every input at the falling edge and compares all outputs 5 ns later against a behavioural queue model. The model advances on the rising edge using the same inputs, so every result is checked in the cycle it is due. The directed checks sample at that point too: the request directly after a push, and the level flag one further cycle later.

// File: rtl/spi_fifo_dma_pkg.sv
package spi_fifo_dma_pkg;

    // Word addresses of the register port
    typedef enum logic {
        ADDR_CTRL  = 1'b0,
        ADDR_FLAGS = 1'b1
    } reg_addr_e;

    // Clock stall machine
    typedef enum logic {
        ST_FLOW = 1'b0,
        ST_HOLD = 1'b1
    } stall_state_e;

    // Control word field positions
    localparam int unsigned CF_RX_THR_LSB = 0;
    localparam int unsigned CF_TX_THR_LSB = 8;
    localparam int unsigned CF_DMA_EN     = 16;
    localparam int unsigned CF_FIFO_EN    = 17;
    localparam int unsigned CF_FLUSH      = 18;
    localparam int unsigned CF_TX_CNT_LSB = 24;

    // Flag word bit positions
    localparam int unsigned FL_TX_LVL = 0;
    localparam int unsigned FL_RX_LVL = 1;
    localparam int unsigned FL_RX_UND = 2;
    localparam int unsigned FL_RX_OVR = 3;
    localparam int unsigned FL_COUNT  = 4;

    localparam int unsigned REG_W = 32;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned WIDTH = 8,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             flush_i,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] count_nxt_o
);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             full, empty, do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count_q == CNT_W'(DEPTH));
    assign empty   = (count_q == '0);
    assign do_push = push_i && !full && !flush_i;
    assign do_pop  = pop_i && !empty && !flush_i;

    always_comb begin
        count_nxt_o = count_q;
        if (flush_i) begin
            count_nxt_o = '0;
        end else if (do_push && !do_pop) begin
            count_nxt_o = count_q + 1'b1;
        end else if (do_pop && !do_push) begin
            count_nxt_o = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            count_q <= count_nxt_o;
            if (flush_i) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
                if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (do_push) mem_q[wr_ptr_q] <= wdata_i;
    end

    assign rdata_o = mem_q[rd_ptr_q];
    assign count_o = count_q;

endmodule

// File: rtl/spi_w1c_flags.sv
module spi_w1c_flags #(
    parameter int unsigned N = 4
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] kill_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flags_q;

    // set beats a software clear; a kill beats both
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            flags_q <= '0;
        end else begin
            flags_q <= ((flags_q & ~clr_i) | set_i) & ~kill_i;
        end
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/spi_rx_stall_fsm.sv
module spi_rx_stall_fsm
    import spi_fifo_dma_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             master_i,
    input  logic [CNT_W-1:0] rx_cnt_nxt_i,
    output logic             stall_o
);

    stall_state_e state_q, state_d;
    logic         full_nxt;

    assign full_nxt = (rx_cnt_nxt_i == CNT_W'(DEPTH));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOW: if (master_i && full_nxt)    state_d = ST_HOLD;  // T_FILL
            ST_HOLD: if (!master_i || !full_nxt)  state_d = ST_FLOW;  // T_DRAIN
            default: state_d = ST_FLOW;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_FLOW;
        else         state_q <= state_d;
    end

    always_comb begin
        stall_o = (state_q == ST_HOLD);
    end

endmodule

// File: rtl/spi_fifo_dma_ctl.sv
module spi_fifo_dma_ctl
    import spi_fifo_dma_pkg::*;
#(
    parameter int unsigned DEPTH      = 32,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned TX_THR_RST = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              reg_wr_i,
    input  logic              reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              master_i,
    input  logic              tx_push_i,
    input  logic [DATA_W-1:0] tx_wdata_i,
    input  logic              tx_pop_i,
    output logic [DATA_W-1:0] tx_data_o,
    input  logic              rx_push_i,
    input  logic [DATA_W-1:0] rx_wdata_i,
    input  logic              rx_pop_i,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              tx_dma_req_o,
    output logic              rx_dma_req_o,
    output logic              stall_o
);

    localparam int unsigned THR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [THR_W-1:0]    rx_thr_q, tx_thr_q;
    logic                tx_dma_en_q, tx_fifo_en_q;
    logic                ctrl_wr, flag_wr, tx_flush;
    logic [CNT_W-1:0]    tx_cnt, rx_cnt, rx_cnt_nxt, unused_tx_cnt_nxt;
    logic                rx_full, rx_empty, tx_lvl, rx_lvl;
    logic [FL_COUNT-1:0] flag_set, flag_clr, flag_kill, flags;
    logic                unused_wdata;

    assign ctrl_wr  = reg_wr_i && (reg_addr_i == ADDR_CTRL);
    assign flag_wr  = reg_wr_i && (reg_addr_i == ADDR_FLAGS);
    assign tx_flush = ctrl_wr && reg_wdata_i[CF_FLUSH];
    assign unused_wdata = ^reg_wdata_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rx_thr_q     <= '0;
            tx_thr_q     <= THR_W'(TX_THR_RST);
            tx_dma_en_q  <= 1'b0;
            tx_fifo_en_q <= 1'b0;
        end else if (ctrl_wr) begin
            rx_thr_q     <= reg_wdata_i[CF_RX_THR_LSB +: THR_W];
            tx_thr_q     <= reg_wdata_i[CF_TX_THR_LSB +: THR_W];
            tx_dma_en_q  <= reg_wdata_i[CF_DMA_EN];
            tx_fifo_en_q <= reg_wdata_i[CF_FIFO_EN];
        end
    end

    spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (tx_flush),
        .push_i      (tx_push_i && tx_fifo_en_q),
        .wdata_i     (tx_wdata_i),
        .pop_i       (tx_pop_i),
        .rdata_o     (tx_data_o),
        .count_o     (tx_cnt),
        .count_nxt_o (unused_tx_cnt_nxt)
    );

    spi_byte_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (1'b0),
        .push_i      (rx_push_i),
        .wdata_i     (rx_wdata_i),
        .pop_i       (rx_pop_i),
        .rdata_o     (rx_data_o),
        .count_o     (rx_cnt),
        .count_nxt_o (rx_cnt_nxt)
    );

    assign rx_full  = (rx_cnt == CNT_W'(DEPTH));
    assign rx_empty = (rx_cnt == '0);
    assign tx_lvl   = (tx_cnt < CNT_W'(tx_thr_q));
    assign rx_lvl   = (rx_cnt > CNT_W'(rx_thr_q));

    assign tx_dma_req_o = tx_dma_en_q && tx_lvl;
    assign rx_dma_req_o = rx_lvl;

    always_comb begin
        flag_set            = '0;
        flag_set[FL_TX_LVL] = tx_lvl;
        flag_set[FL_RX_LVL] = rx_lvl;
        flag_set[FL_RX_UND] = rx_pop_i && rx_empty;
        flag_set[FL_RX_OVR] = rx_push_i && rx_full && !master_i;
        flag_clr            = flag_wr ? reg_wdata_i[FL_COUNT-1:0] : '0;
        flag_kill            = '0;
        flag_kill[FL_TX_LVL] = tx_flush;
    end

    spi_w1c_flags #(.N(FL_COUNT)) u_flags (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .set_i   (flag_set),
        .clr_i   (flag_clr),
        .kill_i  (flag_kill),
        .flags_o (flags)
    );

    spi_rx_stall_fsm #(.DEPTH(DEPTH)) u_stall (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .master_i     (master_i),
        .rx_cnt_nxt_i (rx_cnt_nxt),
        .stall_o      (stall_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_CTRL: begin
                reg_rdata_o[CF_RX_THR_LSB +: THR_W] = rx_thr_q;
                reg_rdata_o[CF_TX_THR_LSB +: THR_W] = tx_thr_q;
                reg_rdata_o[CF_DMA_EN]              = tx_dma_en_q;
                reg_rdata_o[CF_FIFO_EN]             = tx_fifo_en_q;
                reg_rdata_o[CF_TX_CNT_LSB +: CNT_W] = tx_cnt;
            end
            ADDR_FLAGS: reg_rdata_o[FL_COUNT-1:0] = flags;
            default: reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/spi_fifo_dma_ctl_chk.sv
module spi_fifo_dma_ctl_chk #(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             ctrl_wr,
    input logic             flag_wr,
    input logic             wd_flush,
    input logic             wd_dma_en,
    input logic [3:0]       wd_flags,
    input logic             master_i,
    input logic             rx_pop_i,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt,
    input logic [3:0]       flags,
    input logic             tx_dma_req_o,
    input logic             stall_o
);

    assert_flush_empties_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && wd_flush) |=> (tx_cnt == '0));

    assert_dma_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctrl_wr && !wd_dma_en) |=> !tx_dma_req_o);

    assert_underrun_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_pop_i && rx_cnt == '0) |=> flags[2]);

    assert_no_ovr_master_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(flags[3]) |-> !$past(master_i));

    assert_stall_master_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> ($past(master_i) && rx_cnt == CNT_W'(DEPTH)));

    assert_rx_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_cnt <= CNT_W'(DEPTH));

    for (genvar i = 1; i < 4; i++) begin : g_sticky
        assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flags[i] && !(flag_wr && wd_flags[i])) |=> flags[i]);
    end

endmodule

bind spi_fifo_dma_ctl spi_fifo_dma_ctl_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_wr      (ctrl_wr),
    .flag_wr      (flag_wr),
    .wd_flush     (reg_wdata_i[18]),
    .wd_dma_en    (reg_wdata_i[16]),
    .wd_flags     (reg_wdata_i[3:0]),
    .master_i     (master_i),
    .rx_pop_i     (rx_pop_i),
    .tx_cnt       (tx_cnt),
    .rx_cnt       (rx_cnt),
    .flags        (flags),
    .tx_dma_req_o (tx_dma_req_o),
    .stall_o      (stall_o)
);

// File: tb/spi_fifo_dma_ctl_bench.sv
`timescale 1ns/1ps
module spi_fifo_dma_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        master = 1'b0;
    logic        tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0]  tx_wdata = '0, rx_wdata = '0, tx_data, rx_data;
    logic        tx_req, rx_req, stall;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    spi_fifo_dma_ctl u_spi_fifo_dma_ctl (
        .clk_i(clk), .rst_ni(rst_n),
        .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .master_i(master),
        .tx_push_i(tx_push), .tx_wdata_i(tx_wdata), .tx_pop_i(tx_pop), .tx_data_o(tx_data),
        .rx_push_i(rx_push), .rx_wdata_i(rx_wdata), .rx_pop_i(rx_pop), .rx_data_o(rx_data),
        .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req), .stall_o(stall)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_txq[$];
    logic [7:0] m_rxq[$];
    int   m_rx_thr, m_tx_thr;
    bit   m_dma_en, m_fifo_en, m_stall;
    logic [3:0] m_flags;

    always @(posedge clk) begin
        int txn, rxn;
        logic [3:0] set, clr;
        bit flush;
        if (!rst_n) begin
            m_txq.delete(); m_rxq.delete();
            m_rx_thr = 0; m_tx_thr = 16; m_dma_en = 0; m_fifo_en = 0;
            m_stall = 0; m_flags = '0;
        end else begin
            txn = m_txq.size(); rxn = m_rxq.size();
            set[0] = (txn < m_tx_thr);
            set[1] = (rxn > m_rx_thr);
            set[2] = rx_pop && (rxn == 0);
            set[3] = rx_push && (rxn == 32) && !master;
            flush  = reg_wr && !reg_addr && reg_wdata[18];
            clr    = (reg_wr && reg_addr) ? reg_wdata[3:0] : 4'b0;
            m_flags = (m_flags & ~clr) | set;
            if (flush) m_flags[0] = 1'b0;
            if (flush) m_txq.delete();
            else begin
                if (tx_pop && txn > 0) void'(m_txq.pop_front());
                if (tx_push && m_fifo_en && txn < 32) m_txq.push_back(tx_wdata);
            end
            if (rx_pop && rxn > 0) void'(m_rxq.pop_front());
            if (rx_push && rxn < 32) m_rxq.push_back(rx_wdata);
            m_stall = master && (m_rxq.size() == 32);
            if (reg_wr && !reg_addr) begin
                m_rx_thr  = int'(reg_wdata[4:0]);
                m_tx_thr  = int'(reg_wdata[12:8]);
                m_dma_en  = reg_wdata[16];
                m_fifo_en = reg_wdata[17];
            end
        end
    end

    function automatic logic [31:0] exp_rdata(input logic a);
        if (a) return {28'b0, m_flags};
        return 32'(m_rx_thr) | (32'(m_tx_thr) << 8) | (32'(m_dma_en) << 16)
             | (32'(m_fifo_en) << 17) | (32'(m_txq.size()) << 24);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison, 5 ns after the falling edge
    always @(negedge clk) begin
        #5;
        if (rst_n && !done) begin
            check("R4 tx_dma_req", 32'(tx_req), 32'(m_dma_en && (m_txq.size() < m_tx_thr)));
            check("R2 rx_dma_req", 32'(rx_req), 32'(m_rxq.size() > m_rx_thr));
            check("R10 stall", 32'(stall), 32'(m_stall));
            check(reg_addr ? "R11 flag word" : "R7 control word", reg_rdata, exp_rdata(reg_addr));
            if (m_txq.size() > 0) check("R5 tx head", 32'(tx_data), 32'(m_txq[0]));
            if (m_rxq.size() > 0) check("R12 rx head", 32'(rx_data), 32'(m_rxq[0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(); @(negedge clk); endtask
    function automatic logic [31:0] mk(input int rx, input int tx, input bit d, input bit e, input bit f);
        return 32'(rx) | (32'(tx) << 8) | (32'(d) << 16) | (32'(e) << 17) | (32'(f) << 18);
    endfunction
    task automatic wr_reg(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 1'b0;
    endtask
    task automatic push_tx(input logic [7:0] d); tx_push = 1'b1; tx_wdata = d; tick(); tx_push = 1'b0; endtask
    task automatic pop_tx(); tx_pop = 1'b1; tick(); tx_pop = 1'b0; endtask
    task automatic push_rx(input logic [7:0] d); rx_push = 1'b1; rx_wdata = d; tick(); rx_push = 1'b0; endtask
    task automatic pop_rx(); rx_pop = 1'b1; tick(); rx_pop = 1'b0; endtask
    task automatic read_chk(input logic a, input logic [31:0] exp, input string tag);
        reg_addr = a; #3; check(tag, reg_rdata, exp);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL all requirements: watchdog expired, actual hung expected finished");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        // R1 reset state
        read_chk(1'b0, 32'h0000_1000, "R1 control word in reset");
        read_chk(1'b1, 32'h0, "R1 flag word in reset");
        check("R1 requests in reset", {30'b0, tx_req, rx_req}, 32'h0);
        check("R1 stall in reset", 32'(stall), 32'h0);
        tick(); rst_n = 1'b1; tick();

        // R5 push ignored while the TX queue is disabled
        push_tx(8'hA0);
        read_chk(1'b0, 32'h0000_1000, "R5 disabled push ignored");

        wr_reg(1'b0, mk(0, 16, 1, 1, 0));
        for (int i = 1; i <= 5; i++) push_tx(8'hA0 + 8'(i));
        check("R4 request with 5 below 16", 32'(tx_req), 32'h1);
        read_chk(1'b0, 32'h0503_1000, "R7 fill count 5");
        check("R5 tx head order", 32'(tx_data), 32'hA1);
        wr_reg(1'b0, mk(0, 3, 1, 1, 0));
        check("R4 no request with 5 above 3", 32'(tx_req), 32'h0);
        wr_reg(1'b0, mk(0, 16, 1, 1, 0));
        check("R4 request restored", 32'(tx_req), 32'h1);
        wr_reg(1'b0, mk(0, 16, 0, 1, 0));
        check("R4 enable cleared drops request", 32'(tx_req), 32'h0);
        pop_tx();
        check("R5 head after pop", 32'(tx_data), 32'hA2);
        for (int i = 0; i < 30; i++) push_tx(8'(i));
        read_chk(1'b0, 32'h2002_1000, "R7 fill count capped at 32");
        wr_reg(1'b0, mk(0, 16, 0, 1, 0));
        read_chk(1'b0, 32'h2002_1000, "R6 flush bit 0 has no effect");
        // R6 flush with threshold 0: queue empties, level flag cleared and stays clear
        wr_reg(1'b0, mk(0, 0, 0, 1, 1));
        read_chk(1'b0, 32'h0002_0000, "R6 flush empties and reads 0");
        tick();
        read_chk(1'b1, 32'h0, "R6 tx level flag cleared by flush");

        // R2 / R3 receive threshold 1
        wr_reg(1'b0, mk(1, 0, 0, 1, 0));
        push_rx(8'hB1);
        check("R2 one byte not above 1", 32'(rx_req), 32'h0);
        push_rx(8'hB2);
        check("R2 two bytes above 1", 32'(rx_req), 32'h1);
        read_chk(1'b1, 32'h0, "R3 flag not yet set");
        tick();
        read_chk(1'b1, 32'h2, "R3 flag one cycle after request");
        check("R12 rx head order", 32'(rx_data), 32'hB1);
        pop_rx();
        check("R12 rx head after pop", 32'(rx_data), 32'hB2);
        check("R2 request drops at one byte", 32'(rx_req), 32'h0);
        pop_rx();
        pop_rx();
        read_chk(1'b1, 32'h6, "R8 underrun on empty pop");

        // R11 write-one-to-clear behaviour
        wr_reg(1'b1, 32'h0);
        read_chk(1'b1, 32'h6, "R11 writing zero keeps flags");
        wr_reg(1'b1, 32'h4);
        read_chk(1'b1, 32'h2, "R11 writing one clears");
        rx_pop = 1'b1; wr_reg(1'b1, 32'h4); rx_pop = 1'b0;
        read_chk(1'b1, 32'h6, "R11 set wins over clear");
        wr_reg(1'b1, 32'hF);

        // R9 slave overrun
        for (int i = 0; i < 32; i++) push_rx(8'h40 + 8'(i));
        check("R10 no stall in slave mode", 32'(stall), 32'h0);
        push_rx(8'hEE);
        read_chk(1'b1, 32'h8 | 32'h2, "R9 overrun in slave mode");
        check("R12 head unchanged by dropped byte", 32'(rx_data), 32'h40);
        wr_reg(1'b1, 32'hF);
        pop_rx();

        // R10 master stall
        master = 1'b1; tick();
        push_rx(8'h77);
        check("R10 stall when full in master", 32'(stall), 32'h1);
        push_rx(8'h78);
        read_chk(1'b1, 32'h2, "R9 no overrun in master mode");
        check("R10 stall held while full", 32'(stall), 32'h1);
        pop_rx();
        check("R10 stall released on pop", 32'(stall), 32'h0);
        master = 1'b0;

        // mixed traffic against the model
        for (int seg = 0; seg < 2; seg++) begin
            for (int c = 0; c < 3000; c++) begin
                tx_push  = ($urandom % 2) == 0;
                tx_wdata = 8'($urandom);
                tx_pop   = ($urandom % 3) == 0;
                rx_push  = (seg == 0) ? (($urandom % 4) != 0) : (($urandom % 3) == 0);
                rx_wdata = 8'($urandom);
                rx_pop   = (seg == 0) ? (($urandom % 4) == 0) : (($urandom % 2) == 0);
                reg_addr = 1'($urandom);
                reg_wr   = ($urandom % 16) == 0;
                reg_wdata = $urandom;
                if (($urandom % 8) != 0) reg_wdata[18] = 1'b0;
                if (!reg_addr) reg_wdata[17] = 1'b1;
                if (($urandom % 64) == 0) master = ~master;
                tick();
            end
        end
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; reg_wr = 0;
        tick(); tick();
        done = 1'b1;
        summary();
        $finish;
    end

endmodule